// File: doc/BRIEF.md
# Double-Pulse Blink and Fade Sequencer

This block sequences the light intensity of one bank of indicator outputs. Each blink cycle carries two identical light pulses. A pulse ramps up from dark, holds at the bank's peak level and ramps back down. Each pulse is followed by its own dark gap, and the two gaps can differ, which gives a double-blink. Every stretch of the cycle takes its length from a 4-bit time code. The codes map nonlinearly onto durations of 0 to 16320 ticks of a 1 ms strobe.

A restart strobe drops the sequence into any of its eight regions. In one-shot mode the block then reports the end of that starting region. The report is a single-cycle pulse, and it carries whether the output should stay lit at peak or stay dark. The sequence itself keeps cycling, so other outputs that share the bank see no disturbance. Turning the level into a duty cycle and routing it to pins are handled elsewhere.

Top module: `blink_sequencer`

## Requirements
- R1: After reset, region is 0, level is 0 and done is 0.
- R2: The region output steps 0,1,2,3,4,5,6,7 and then wraps to 0. These codes mean rise 1, hold 1, fall 1, gap 1, rise 2, hold 2, fall 2 and gap 2. Regions 0 and 4 use rise_code, regions 1 and 5 use hold_code, regions 2 and 6 use fall_code, region 3 uses gap1_code and region 7 uses gap2_code.
- R3: A region whose code is c lasts T(c) ticks. T(0..15) = 0, 64, 128, 192, 256, 384, 512, 768, 1024, 1536, 2048, 3072, 4096, 5760, 8128, 16320.
- R4: When a region ends, every following region whose duration is 0 is skipped on that same tick. If all eight durations are 0, the region advances by one on every tick.
- R5: In regions 1 and 5 the level equals peak. In regions 3 and 7 the level is 0.
- R6: With e ticks elapsed in a region of duration d, the level in a rise region is floor(peak*e/d) and in a fall region is floor(peak*(d-e)/d). When e >= d, a rise region shows peak and a fall region shows 0.
- R7: A restart puts the region at restart_region with e = 0 on the next edge, and it takes priority over a tick in the same cycle.
- R8: If one_shot is 1 at a restart, the tick that ends the starting region raises done for exactly one cycle, starting on the next edge. With it, done_on is 1 if that region was 0, 1, 4 or 5 and 0 otherwise. The sequence carries on into the next region.
- R9: Without tick or restart, neither region nor level changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 1 ms time base strobe |
| rise_code | input | 4 | Time code of both rise regions |
| hold_code | input | 4 | Time code of both hold regions |
| fall_code | input | 4 | Time code of both fall regions |
| gap1_code | input | 4 | Time code of the first dark gap |
| gap2_code | input | 4 | Time code of the second dark gap |
| peak | input | LW | Effective maximum intensity of the bank |
| one_shot | input | 1 | One-shot mode, sampled at restart |
| restart | input | 1 | Restart strobe |
| restart_region | input | 3 | Region to restart in |
| level | output | LW | Current intensity level |
| region | output | 3 | Current region |
| done | output | 1 | One-shot completion pulse |
| done_on | output | 1 | Final state for one-shot: 1 lit at peak, 0 dark |

## Verification
Default codes with a tick on every cycle drive a full, symmetric double-pulse cycle, which exposes the region order and the linear ramps. Mixed codes with a zero gap, together with sparse and irregular ticks, separate tick counting from clock counting and confirm that zero-length regions are skipped. A one-shot restart from each of the eight regions tells the lit end states apart from the dark ones. An all-zero code set and a restart coinciding with a tick probe the degenerate advance and the restart priority.

// File: rtl/blink_sequencer.sv
module blink_sequencer #(
  parameter int TW = 14,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [3:0]    rise_code,
  input  logic [3:0]    hold_code,
  input  logic [3:0]    fall_code,
  input  logic [3:0]    gap1_code,
  input  logic [3:0]    gap2_code,
  input  logic [LW-1:0] peak,
  input  logic          one_shot,
  input  logic          restart,
  input  logic [2:0]    restart_region,
  output logic [LW-1:0] level,
  output logic [2:0]    region,
  output logic          done,
  output logic          done_on
);
  localparam int PW = LW + TW;

  function automatic logic [TW-1:0] ticks_of(input logic [3:0] c);
    case (c)
      4'd0:  return TW'(0);
      4'd1:  return TW'(64);
      4'd2:  return TW'(128);
      4'd3:  return TW'(192);
      4'd4:  return TW'(256);
      4'd5:  return TW'(384);
      4'd6:  return TW'(512);
      4'd7:  return TW'(768);
      4'd8:  return TW'(1024);
      4'd9:  return TW'(1536);
      4'd10: return TW'(2048);
      4'd11: return TW'(3072);
      4'd12: return TW'(4096);
      4'd13: return TW'(5760);
      4'd14: return TW'(8128);
      default: return TW'(16320);
    endcase
  endfunction

  logic [TW-1:0] elapsed;
  logic          armed;
  logic [TW-1:0] dur_of [8];
  logic [2:0]    nxt;
  logic [TW-1:0] dur;
  logic          last;
  logic [PW-1:0] num;

  always_comb begin
    for (int r = 0; r < 8; r++) begin
      logic [2:0] rr;
      rr = 3'(r);
      case (rr[1:0])
        2'd0:    dur_of[r] = ticks_of(rise_code);
        2'd1:    dur_of[r] = ticks_of(hold_code);
        2'd2:    dur_of[r] = ticks_of(fall_code);
        default: dur_of[r] = ticks_of(rr[2] ? gap2_code : gap1_code);
      endcase
    end
  end

  always_comb begin
    logic found;
    logic [2:0] cand;
    found = 1'b0;
    nxt = region + 3'd1;
    for (int k = 1; k <= 8; k++) begin
      cand = region + 3'(k);
      if (!found && dur_of[cand] != '0) begin
        nxt = cand;
        found = 1'b1;
      end
    end
  end

  assign dur  = dur_of[region];
  assign last = ({1'b0, elapsed} + 1'b1) >= {1'b0, dur};

  always_comb begin
    num   = '0;
    level = '0;
    case (region[1:0])
      2'd1: level = peak;
      2'd3: level = '0;
      2'd0: begin
        if (elapsed >= dur) level = peak;
        else begin
          num   = PW'(peak) * PW'(elapsed);
          level = LW'(num / PW'(dur));
        end
      end
      default: begin
        if (elapsed < dur) begin
          num   = PW'(peak) * PW'(dur - elapsed);
          level = LW'(num / PW'(dur));
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      region  <= '0;
      elapsed <= '0;
      armed   <= 1'b0;
      done    <= 1'b0;
      done_on <= 1'b0;
    end else begin
      done <= 1'b0;
      if (restart) begin
        region  <= restart_region;
        elapsed <= '0;
        armed   <= one_shot;
      end else if (tick) begin
        if (last) begin
          region  <= nxt;
          elapsed <= '0;
          if (armed) begin
            done    <= 1'b1;
            done_on <= ~region[1];
            armed   <= 1'b0;
          end
        end else begin
          elapsed <= elapsed + 1'b1;
        end
      end
    end
  end

  assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> ($stable(region) && $stable(elapsed)));

  assert_restart_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (region == $past(restart_region)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_on == !$past(region[1])));

  assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    level <= peak);

  assert_done_needs_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tick && !restart));
endmodule

// File: tb/blink_sequencer_tb.sv
module blink_sequencer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [3:0] rise_code = 4'd4, hold_code = 4'd4, fall_code = 4'd4, gap1_code = 4'd4, gap2_code = 4'd4;
  logic [3:0] peak = 4'd15;
  logic one_shot = 1'b0, restart = 1'b0;
  logic [2:0] restart_region = 3'd0;
  logic [3:0] level;
  logic [2:0] region;
  logic done, done_on;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;

  int m_reg = 0, m_el = 0, m_armed = 0, m_done = 0, m_don = 0;
  int tbl[16] = '{0, 64, 128, 192, 256, 384, 512, 768, 1024, 1536, 2048, 3072, 4096, 5760, 8128, 16320};

  always #5 clk = ~clk;

  blink_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .rise_code(rise_code), .hold_code(hold_code), .fall_code(fall_code),
    .gap1_code(gap1_code), .gap2_code(gap2_code), .peak(peak),
    .one_shot(one_shot), .restart(restart), .restart_region(restart_region),
    .level(level), .region(region), .done(done), .done_on(done_on)
  );

  function automatic int span(int r);
    if (r == 0 || r == 4) return tbl[rise_code];
    if (r == 1 || r == 5) return tbl[hold_code];
    if (r == 2 || r == 6) return tbl[fall_code];
    if (r == 3) return tbl[gap1_code];
    return tbl[gap2_code];
  endfunction

  function automatic int following(int r);
    for (int k = 1; k <= 8; k++)
      if (span((r + k) % 8) != 0) return (r + k) % 8;
    return (r + 1) % 8;
  endfunction

  function automatic int expect_level();
    int d;
    d = span(m_reg);
    if (m_reg == 1 || m_reg == 5) return peak;
    if (m_reg == 3 || m_reg == 7) return 0;
    if (m_reg == 0 || m_reg == 4) begin
      if (m_el >= d) return peak;
      return (peak * m_el) / d;
    end
    if (m_el >= d) return 0;
    return (peak * (d - m_el)) / d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 0; m_el = 0; m_armed = 0; m_done = 0; m_don = 0;
    end else begin
      m_done = 0;
      if (restart) begin
        m_reg = restart_region; m_el = 0; m_armed = one_shot;
      end else if (tick) begin
        if (m_el + 1 >= span(m_reg)) begin
          if (m_armed != 0) begin
            m_done = 1;
            m_don = (m_reg % 4 < 2) ? 1 : 0;
            m_armed = 0;
          end
          m_reg = following(m_reg);
          m_el = 0;
        end else begin
          m_el = m_el + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (region != m_reg) begin
        errors++;
        $display("FAIL R2 region order: actual %0d expected %0d", region, m_reg);
      end
      if (level != expect_level()) begin
        errors++;
        $display("FAIL %s level in region %0d: actual %0d expected %0d",
                 (m_reg % 2 == 1) ? "R5" : "R6", m_reg, level, expect_level());
      end
      if (done != m_done[0] || (m_done != 0 && done_on != m_don[0])) begin
        errors++;
        $display("FAIL R8 done/done_on: actual %0d/%0d expected %0d/%0d", done, done_on, m_done, m_don);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_restart(input int r, input bit os, input bit with_tick);
    restart_region = 3'(r);
    one_shot = os;
    restart = 1'b1;
    tick = with_tick;
    step(1);
    restart = 1'b0;
    one_shot = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int r_hold;
    int seen_gap;
    int waited;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk(region == 3'd0 && level == 4'd0 && done == 1'b0, "R1 reset state", {region, level, done}, 0);

    step(20);
    chk(region == 3'd0 && level == 4'd0, "R9 no tick holds state", region, 0);

    tick = 1'b1;
    step(2100);

    rise_code = 4'd1; hold_code = 4'd2; fall_code = 4'd1; gap1_code = 4'd0; gap2_code = 4'd1; peak = 4'd11;
    do_restart(0, 1'b0, 1'b1);
    step(63);
    chk(region == 3'd0, "R3 rise of code 1 still running at tick 63", region, 0);
    step(1);
    chk(region == 3'd1, "R3 rise of code 1 ends at tick 64", region, 1);

    while (region != 3'd2) step(1);
    while (region == 3'd2) step(1);
    chk(region == 3'd4, "R4 zero gap skipped", region, 4);

    tick = 1'b0;
    r_hold = region;
    step(30);
    chk(region == 3'(r_hold), "R9 region held without tick", region, r_hold);

    rise_code = 4'd2; hold_code = 4'd1; fall_code = 4'd3; gap1_code = 4'd1; gap2_code = 4'd0; peak = 4'd7;
    seen_gap = 0;
    for (int i = 0; i < 3000; i++) begin
      tick = ($urandom % 3) == 0;
      step(1);
      if (region == 3'd7) seen_gap = 1;
    end
    chk(seen_gap == 0, "R4 zero second gap never shown", seen_gap, 0);

    rise_code = 4'd1; hold_code = 4'd1; fall_code = 4'd1; gap1_code = 4'd1; gap2_code = 4'd1; peak = 4'd13;
    for (int s = 0; s < 8; s++) begin
      do_restart(s, 1'b1, 1'b0);
      tick = 1'b1;
      waited = 0;
      while (!done && waited < 200) begin
        step(1);
        waited++;
      end
      chk(done == 1'b1 && done_on == ((s % 4) < 2), "R8 one-shot final state", done_on, (s % 4) < 2);
      chk(region == 3'((s + 1) % 8), "R8 cycle continues after one-shot", region, (s + 1) % 8);
      step(1);
      chk(done == 1'b0, "R8 done lasts one cycle", done, 0);
    end

    do_restart(5, 1'b0, 1'b1);
    chk(region == 3'd5, "R7 restart beats tick", region, 5);
    tick = 1'b1;
    step(30);
    chk(region == 3'd5 && level == peak, "R5 hold level equals peak", level, peak);
    peak = 4'd6;
    step(1);
    chk(level == 4'd6, "R5 hold follows peak change", level, 6);

    do_restart(3, 1'b0, 1'b0);
    tick = 1'b1;
    step(10);
    chk(level == 4'd0, "R5 gap level zero", level, 0);

    rise_code = 4'd0; hold_code = 4'd0; fall_code = 4'd0; gap1_code = 4'd0; gap2_code = 4'd0;
    do_restart(2, 1'b0, 1'b0);
    tick = 1'b1;
    step(3);
    chk(region == 3'd5, "R4 all-zero codes advance one per tick", region, 5);

    rise_code = 4'd1; fall_code = 4'd2; peak = 4'd15;
    do_restart(0, 1'b0, 1'b0);
    tick = 1'b1;
    step(32);
    chk(level == 4'd7, "R6 rise halfway level", level, 7);

    tick = 1'b0;
    step(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule